// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is an 8-bit memory-mapped control register that sits between software and a microcontroller's power manager. A write can ask for one of three low-power modes: stop, time-base timer or sleep. Each request bit is edge-like: only its active write value does anything, and its readback is fixed. When one write asks for several modes at once, a fixed priority picks one. The chosen request output stays asserted until the wake-up logic returns the matching release.

The same register holds a pin-float enable, which matters only in the two deep modes (stop and time-base timer). It also holds a two-bit CPU halt-cycle selection, and a command bit that fires a short internal reset pulse. The reset inputs are synchronous and active low. Any of them clears the requests, the float enable and a running pulse. Only power-on and watchdog reset clear the halt selection.

Top module: `pwr_mode_ctl`

## Requirements
- R1: A selected write (bus_sel and bus_wr high) with bit 7 at 1 raises req_stop from the next clock edge; a write with bus_sel low has no effect.
- R2: A selected write with bit 6 at 1 and bit 7 at 0 and bit 3 at 1 raises req_sleep from the next edge.
- R3: A selected write with bit 3 at 0 and bit 7 at 0 raises req_tbt from the next edge; bit 3 at 1 requests nothing.
- R4: When one write requests several modes, stop is taken over time-base timer, and time-base timer over sleep.
- R5: At most one request output is high. While one is high, mode-request writes are ignored and release inputs of other modes are ignored; its own release input (rel_stop, rel_tbt or rel_sleep) drops it at the next edge.
- R6: A selected read (bus_sel and bus_rd) returns bit 7 = 0, bit 6 = 0, bit 5 = stored float enable, bit 4 = 1, bit 3 = 1, bits 2:1 = stored halt selection, bit 0 = 1; otherwise bus_rdata is 0.
- R7: Bit 5 is stored on every selected write; pin_float is high only while that bit is 1 and req_stop or req_tbt is high.
- R8: A selected write with bit 4 at 0 drives int_rst high for exactly RST_CYCLES (default 3) cycles from the next edge; such writes during a pulse do not extend it, and the pulse changes no stored field.
- R9: Bits 2:1 are stored on every selected write and drive halt_sel; only rst_por_n or rst_wdt_n low clears them, and rst_oth_n low leaves them unchanged.
- R10: Any reset input low at a clock edge clears all request outputs, the stored float enable and int_rst.
- R11: The value written to bit 0 has no effect on outputs or readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_wdt_n | input | 1 | Watchdog reset, synchronous, active low |
| rst_oth_n | input | 1 | Any other reset source, synchronous, active low |
| bus_sel | input | 1 | Register selected by the address decoder |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not read |
| rel_stop | input | 1 | Stop mode released by wake-up logic |
| rel_tbt | input | 1 | Time-base timer mode released |
| rel_sleep | input | 1 | Sleep mode released |
| req_stop | output | 1 | Stop mode request |
| req_tbt | output | 1 | Time-base timer mode request |
| req_sleep | output | 1 | Sleep mode request |
| pin_float | output | 1 | Float the external pins to high impedance |
| int_rst | output | 1 | Internal reset pulse |
| halt_sel | output | 2 | CPU halt-cycle count selection |

## Verification
The assertions assume the three reset inputs are sampled only at clock edges, and that a release input which arrives while its mode is not held can be ignored. They also assume a write and its data are stable at the edge that samples them. The stimulus changes every input only at the falling edge. It pulses each release for one cycle, sometimes while the wrong mode is held. Each reset source is asserted for whole cycles, including once while a reset pulse is running.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
    localparam int REG_W     = 8;
    localparam int HALT_W    = 2;
    localparam int B_STOP    = 7;
    localparam int B_SLEEP   = 6;
    localparam int B_FLOAT   = 5;
    localparam int B_IRST    = 4;
    localparam int B_TBT     = 3;
    localparam int B_HALT_LO = 1;
    localparam int B_RSV     = 0;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_STOP  = 2'd1,
        PM_TBT   = 2'd2,
        PM_SLEEP = 2'd3
    } pm_mode_e;

    // Readback image: trigger bits show their inactive level, stored fields show their state.
    function automatic logic [REG_W-1:0] read_image(input logic flt, input logic [HALT_W-1:0] halt);
        logic [REG_W-1:0] img;
        img = '0;
        img[B_STOP]  = 1'b0;
        img[B_SLEEP] = 1'b0;
        img[B_FLOAT] = flt;
        img[B_IRST]  = 1'b1;
        img[B_TBT]   = 1'b1;
        img[B_HALT_LO +: HALT_W] = halt;
        img[B_RSV]   = 1'b1;
        return img;
    endfunction
endpackage

// File: rtl/pmc_mode_arb.sv
`timescale 1ns/1ps
module pmc_mode_arb
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     any_rst,
    input  logic     wr_en,
    input  logic     want_stop,
    input  logic     want_tbt,
    input  logic     want_sleep,
    input  logic     rel_stop,
    input  logic     rel_tbt,
    input  logic     rel_sleep,
    output pm_mode_e mode_o
);
    typedef struct packed {
        pm_mode_e mode;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    own_rel;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_RUN: begin
                if (wr_en) begin
                    if (want_stop)       st_d.mode = PM_STOP;
                    else if (want_tbt)   st_d.mode = PM_TBT;
                    else if (want_sleep) st_d.mode = PM_SLEEP;
                end
            end
            PM_STOP:  if (rel_stop)  st_d.mode = PM_RUN;
            PM_TBT:   if (rel_tbt)   st_d.mode = PM_RUN;
            PM_SLEEP: if (rel_sleep) st_d.mode = PM_RUN;
            default:  st_d.mode = PM_RUN;
        endcase
        if (any_rst) st_d.mode = PM_RUN;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

    assign own_rel = (st_q.mode == PM_STOP  && rel_stop) ||
                     (st_q.mode == PM_TBT   && rel_tbt)  ||
                     (st_q.mode == PM_SLEEP && rel_sleep);

    AST_STOP_FIRST: assert property (@(posedge clk) disable iff (any_rst)
        (wr_en && mode_o == PM_RUN && want_stop) |=> (mode_o == PM_STOP)); // R4
    AST_TBT_OVER_SLEEP: assert property (@(posedge clk) disable iff (any_rst)
        (wr_en && mode_o == PM_RUN && !want_stop && want_tbt) |=> (mode_o == PM_TBT)); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (any_rst)
        (mode_o != PM_RUN && !own_rel) |=> $stable(mode_o)); // R5
    AST_MODE_RELEASE: assert property (@(posedge clk) disable iff (any_rst)
        own_rel |=> (mode_o == PM_RUN)); // R5
endmodule

// File: rtl/pmc_rst_pulse.sv
`timescale 1ns/1ps
module pmc_rst_pulse #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic any_rst,
    input  logic fire,
    output logic pulse
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam int RW = $clog2(CYCLES + 2);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pls_st_t;

    pls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        else if (fire)       st_d.cnt = LOAD;
        if (any_rst)         st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pulse = (st_q.cnt != '0);

    // Checker: length of the current run of pulse cycles.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (any_rst)    run_q <= '0;
        else if (pulse) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (any_rst)
        run_q <= RW'(CYCLES)); // R8
    AST_PULSE_FULL: assert property (@(posedge clk) disable iff (any_rst)
        ($fell(pulse) && !$past(any_rst)) |-> (run_q == RW'(CYCLES))); // R8
endmodule

// File: rtl/pmc_cfg_store.sv
`timescale 1ns/1ps
module pmc_cfg_store #(
    parameter int HW = 2
) (
    input  logic          clk,
    input  logic          any_rst,
    input  logic          hard_rst,
    input  logic          wr_en,
    input  logic          float_in,
    input  logic [HW-1:0] halt_in,
    output logic          float_o,
    output logic [HW-1:0] halt_o
);
    typedef struct packed {
        logic          flt;
        logic [HW-1:0] halt;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.flt  = float_in;
            st_d.halt = halt_in;
        end
        if (any_rst)  st_d.flt  = 1'b0;
        if (hard_rst) st_d.halt = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign float_o = st_q.flt;
    assign halt_o  = st_q.halt;

    AST_HALT_SOFT_KEEP: assert property (@(posedge clk) disable iff (hard_rst)
        !wr_en |=> $stable(halt_o)); // R9
    AST_FLOAT_CLR: assert property (@(posedge clk)
        any_rst |=> !float_o); // R10
endmodule

// File: rtl/pwr_mode_ctl.sv
`timescale 1ns/1ps
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int RST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_wdt_n,
    input  logic              rst_oth_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rel_stop,
    input  logic              rel_tbt,
    input  logic              rel_sleep,
    output logic              req_stop,
    output logic              req_tbt,
    output logic              req_sleep,
    output logic              pin_float,
    output logic              int_rst,
    output logic [HALT_W-1:0] halt_sel
);
    logic     hard_rst, any_rst, wr_en, fire;
    logic     flt_q;
    pm_mode_e mode;

    assign hard_rst = !rst_por_n || !rst_wdt_n;
    assign any_rst  = hard_rst || !rst_oth_n;
    assign wr_en    = bus_sel && bus_wr;
    assign fire     = wr_en && !bus_wdata[B_IRST];

    pmc_mode_arb u_arb (
        .clk        (clk),
        .any_rst    (any_rst),
        .wr_en      (wr_en),
        .want_stop  (bus_wdata[B_STOP]),
        .want_tbt   (!bus_wdata[B_TBT]),
        .want_sleep (bus_wdata[B_SLEEP]),
        .rel_stop   (rel_stop),
        .rel_tbt    (rel_tbt),
        .rel_sleep  (rel_sleep),
        .mode_o     (mode)
    );

    pmc_rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk     (clk),
        .any_rst (any_rst),
        .fire    (fire),
        .pulse   (int_rst)
    );

    pmc_cfg_store #(.HW(HALT_W)) u_cfg (
        .clk      (clk),
        .any_rst  (any_rst),
        .hard_rst (hard_rst),
        .wr_en    (wr_en),
        .float_in (bus_wdata[B_FLOAT]),
        .halt_in  (bus_wdata[B_HALT_LO +: HALT_W]),
        .float_o  (flt_q),
        .halt_o   (halt_sel)
    );

    assign req_stop  = (mode == PM_STOP);
    assign req_tbt   = (mode == PM_TBT);
    assign req_sleep = (mode == PM_SLEEP);
    assign pin_float = flt_q && (req_stop || req_tbt);
    assign bus_rdata = (bus_sel && bus_rd) ? read_image(flt_q, halt_sel) : '0;

    AST_RST_CLEARS: assert property (@(posedge clk)
        any_rst |=> (!req_stop && !req_tbt && !req_sleep && !int_rst && !pin_float)); // R10
endmodule

// File: tb/pwr_mode_ctl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_por_n = 1'b0, rst_wdt_n = 1'b1, rst_oth_n = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h19;
    logic [7:0] bus_rdata;
    logic       rel_stop = 1'b0, rel_tbt = 1'b0, rel_sleep = 1'b0;
    logic       req_stop, req_tbt, req_sleep, pin_float, int_rst;
    logic [1:0] halt_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctl u_pwr_mode_ctl (
        .clk(clk), .rst_por_n(rst_por_n), .rst_wdt_n(rst_wdt_n), .rst_oth_n(rst_oth_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rel_stop(rel_stop), .rel_tbt(rel_tbt), .rel_sleep(rel_sleep),
        .req_stop(req_stop), .req_tbt(req_tbt), .req_sleep(req_sleep),
        .pin_float(pin_float), .int_rst(int_rst), .halt_sel(halt_sel)
    );

    // expected: {stop,tbt,sleep,float,irst,halt[1:0],check_rd,rdata[7:0]}
    logic [15:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [15:0] mk(input logic s, t, l, f, i, input logic [1:0] h,
                                       input logic c, input logic [7:0] r);
        return {s, t, l, f, i, h, c, r};
    endfunction

    // kind: 0 idle, 1 write, 2 read, 3 unselected write
    task automatic step(input int kind, input logic [7:0] d, input logic [2:0] rel,
                        input logic [2:0] rn, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_sel   = (kind == 1 || kind == 2);
        bus_wr    = (kind == 1 || kind == 3);
        bus_rd    = (kind == 2);
        bus_wdata = d;
        {rel_stop, rel_tbt, rel_sleep}    = rel;
        {rst_por_n, rst_wdt_n, rst_oth_n} = rn;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge while the driven inputs are still held.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            logic [15:0] a;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {req_stop, req_tbt, req_sleep, pin_float, int_rst, halt_sel, e[8],
                 (e[8] ? bus_rdata : e[7:0])};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual %h expected %h", t, a, e);
            end
        end
    end

    localparam logic [2:0] NR = 3'b000;
    localparam logic [2:0] OK = 3'b111;

    initial begin
        step(0, 8'h19, NR, 3'b011, mk(0,0,0,0,0,2'd0,0,8'h00), "R10 power-on reset state");
        step(2, 8'h19, NR, 3'b011, mk(0,0,0,0,0,2'd0,1,8'h19), "R6 readback in reset");
        step(0, 8'h19, NR, OK,     mk(0,0,0,0,0,2'd0,0,8'h00), "R10 idle after reset");
        step(3, 8'h80, NR, OK,     mk(0,0,0,0,0,2'd0,1,8'h00), "R1 unselected write ignored");
        step(1, 8'h3C, NR, OK,     mk(0,0,0,0,0,2'd2,0,8'h00), "R7 R9 R11 neutral write");
        step(2, 8'h00, NR, OK,     mk(0,0,0,0,0,2'd2,1,8'h3D), "R6 R11 stored fields read");
        step(1, 8'h7D, NR, OK,     mk(0,0,1,0,0,2'd2,0,8'h00), "R2 sleep request");
        step(2, 8'h00, NR, OK,     mk(0,0,1,0,0,2'd2,1,8'h3D), "R6 sleep bit reads 0");
        step(1, 8'hBD, NR, OK,     mk(0,0,1,0,0,2'd2,0,8'h00), "R5 write while busy ignored");
        step(0, 8'h19, 3'b110, OK, mk(0,0,1,0,0,2'd2,0,8'h00), "R5 foreign release ignored");
        step(0, 8'h19, 3'b001, OK, mk(0,0,0,0,0,2'd2,0,8'h00), "R5 sleep released");
        step(1, 8'hF5, NR, OK,     mk(1,0,0,1,0,2'd2,0,8'h00), "R4 R7 all three, stop wins");
        step(2, 8'h00, NR, OK,     mk(1,0,0,1,0,2'd2,1,8'h3D), "R6 stop bit reads 0");
        step(0, 8'h19, 3'b100, OK, mk(0,0,0,0,0,2'd2,0,8'h00), "R5 stop released");
        step(1, 8'h75, NR, OK,     mk(0,1,0,1,0,2'd2,0,8'h00), "R3 R4 tbt over sleep");
        step(0, 8'h19, 3'b010, OK, mk(0,0,0,0,0,2'd2,0,8'h00), "R3 tbt released");
        step(1, 8'h15, NR, OK,     mk(0,1,0,0,0,2'd2,0,8'h00), "R7 float off keeps pins");
        step(0, 8'h19, 3'b010, OK, mk(0,0,0,0,0,2'd2,0,8'h00), "R3 tbt released again");
        step(1, 8'h0D, NR, OK,     mk(0,0,0,0,1,2'd2,0,8'h00), "R8 pulse cycle 1");
        step(1, 8'h0D, NR, OK,     mk(0,0,0,0,1,2'd2,0,8'h00), "R8 retrigger cycle 2");
        step(0, 8'h19, NR, OK,     mk(0,0,0,0,1,2'd2,0,8'h00), "R8 pulse cycle 3");
        step(0, 8'h19, NR, OK,     mk(0,0,0,0,0,2'd2,0,8'h00), "R8 pulse ends after 3");
        step(2, 8'h00, NR, OK,     mk(0,0,0,0,0,2'd2,1,8'h1D), "R8 fields kept by pulse");
        step(1, 8'hBD, NR, OK,     mk(1,0,0,1,0,2'd2,0,8'h00), "R1 stop request");
        step(0, 8'h19, NR, 3'b110, mk(0,0,0,0,0,2'd2,0,8'h00), "R9 R10 other reset");
        step(2, 8'h00, NR, OK,     mk(0,0,0,0,0,2'd2,1,8'h1D), "R10 float cleared");
        step(1, 8'h0D, NR, OK,     mk(0,0,0,0,1,2'd2,0,8'h00), "R8 pulse start");
        step(0, 8'h19, NR, 3'b110, mk(0,0,0,0,0,2'd2,0,8'h00), "R10 reset aborts pulse");
        step(0, 8'h19, NR, 3'b101, mk(0,0,0,0,0,2'd0,0,8'h00), "R9 watchdog clears halt");
        step(2, 8'h00, NR, OK,     mk(0,0,0,0,0,2'd0,1,8'h19), "R6 after watchdog");
        step(1, 8'h3B, NR, OK,     mk(0,0,0,0,0,2'd1,0,8'h00), "R9 halt 01 stored");
        step(0, 8'h19, NR, 3'b011, mk(0,0,0,0,0,2'd0,0,8'h00), "R9 power-on clears halt");
        step(1, 8'hD9, NR, OK,     mk(1,0,0,0,0,2'd0,0,8'h00), "R4 stop over sleep");
        step(0, 8'h19, 3'b100, OK, mk(0,0,0,0,0,2'd0,0,8'h00), "R5 final release");
        step(0, 8'h19, NR, OK,     mk(0,0,0,0,0,2'd0,0,8'h00), "R1 idle end");
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule